// File: doc/BRIEF.md
# System control and I/O register block

This block is a small register peripheral for a 32-bit bus with the usual select, enable and write-strobe handshake. It drives a row of user LEDs. It can sample a bank of board switches when that option is built in. It also keeps two free-running time counters. The first is a 100 Hz timebase, whose divider comes from the system clock frequency parameter. The second is a reloadable prescaler that down-counts once per system clock; each time it underflows, it bumps an event counter.

Every access completes in its access phase and never stalls. A read of an offset that holds no register returns zero and raises a one-cycle bad-access strobe. The number of LEDs and the presence of the switch register are fixed at build time. An LED count above the supported maximum stops elaboration.

Top module: `sysio_regs`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `led_o` is zero, and PRESCALE, the prescale down-counter, MISC, COUNTER and the 100 Hz counter all read zero.
- R2: A write to byte offset 0x00 keeps the low NUM_LEDS bits of `pwdata`. Register bit i drives `led_o[i]` high when set. A read of 0x00 returns those bits zero-extended.
- R3: The 100 Hz counter at 0x14 increments by one every CLK_HZ/100 system clocks and wraps at 2^32. Writes to it are ignored.
- R4: The down-counter at 0x20 decrements once per clock. In the cycle after it reads zero, it holds the PRESCALE value, and the event counter at 0x18 is one higher.
- R5: PRESCALE at 0x1C is read/write. A new value does not alter the running down-counter; it is first used at the next reload.
- R6: Writes to 0x18 and 0x20 change neither counter.
- R7: With HAS_SWITCHES set, a read of 0x28 returns `sw_i` delayed through two flops, zero-extended to 32 bits.
- R8: MISC at 0x4C is a plain 32-bit read/write register.
- R9: A read of any offset that holds no register returns zero. During its access phase, `bad_acc` is high for one cycle. A write there changes no register. With HAS_SWITCHES clear, 0x28 counts as such an offset.
- R10: NUM_LEDS may be 0 to 32; a larger value is an elaboration error. With NUM_LEDS at 0, `led_o` stays zero and 0x00 reads zero after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Block selected |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Word address (byte address bits 11:2) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed word |
| bad_acc | output | 1 | High during the access phase of an access to an unmapped offset |
| led_o | output | max(NUM_LEDS,1) | LED drive, active high |
| sw_i | input | NUM_SW | Asynchronous switch inputs |

## Verification
The bench targets the prescaler's reload moment, where a freshly written PRESCALE must wait for the next underflow. A design that loads it at once would show a jump in the down-counter read back. Writes to read-only counters and to unmapped words are mixed into the traffic; a decoder that lets them through would make a counter or MISC diverge from the model. A second instance built without LEDs or switches checks that 0x28 falls back to the unmapped path and that LED writes vanish. Switch reads taken right after an input change expose a synchroniser with the wrong depth.

// File: rtl/sysio_pkg.sv
// Shared constants for the system control and I/O register block.
// Assumes a 32-bit data bus and word-addressed decode (byte bits 11:2).
package sysio_pkg;
    typedef logic [31:0] word_t;

    localparam int MAX_LEDS = 32;

    // Word indices; software-visible byte offset = index * 4
    localparam logic [9:0] WA_LED   = 10'h000;
    localparam logic [9:0] WA_TICK  = 10'h005;
    localparam logic [9:0] WA_EVCNT = 10'h006;
    localparam logic [9:0] WA_RELD  = 10'h007;
    localparam logic [9:0] WA_DOWN  = 10'h008;
    localparam logic [9:0] WA_SW    = 10'h00A;
    localparam logic [9:0] WA_MISC  = 10'h013;
endpackage

// File: rtl/sysio_tick.sv
// 100 Hz timebase: divides the system clock by DIV and counts the ticks.
// Assumes DIV >= 1; the 32-bit count wraps freely.
module sysio_tick #(
    parameter int DIV = 200000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output sysio_pkg::word_t     count_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    logic [DW-1:0]    div_q;
    sysio_pkg::word_t cnt_q;

    // Divider and tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            cnt_q <= cnt_q + 32'd1;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    assign count_o = cnt_q;

    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != DIV_LAST) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/sysio_presc.sv
// Reloadable down-counter feeding an event counter.
// On the clock after the down-counter is zero it takes reload_i and the
// event counter advances; otherwise it decrements by one.
module sysio_presc (
    input  logic             clk,
    input  logic             rst_n,
    input  sysio_pkg::word_t reload_i,
    output sysio_pkg::word_t down_o,
    output sysio_pkg::word_t events_o
);
    sysio_pkg::word_t down_q, ev_q;

    // Down-count, reload on zero, count underflows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_q <= '0;
            ev_q   <= '0;
        end else if (down_q == '0) begin
            down_q <= reload_i;
            ev_q   <= ev_q + 32'd1;
        end else begin
            down_q <= down_q - 32'd1;
        end
    end

    assign down_o   = down_q;
    assign events_o = ev_q;

    AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (down_q != '0) |=> $stable(ev_q)); // R4
    AST_EV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (down_q == '0) |=> (ev_q == $past(ev_q) + 32'd1)); // R4
endmodule

// File: rtl/sysio_sync.sv
// Two-flop synchroniser for slow asynchronous level inputs.
// Assumes the inputs are quasi-static (board switches); no bus coherency.
module sysio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    // Two-stage capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/sysio_regs.sv
// System control and I/O register block (top).
// Bus: access completes in the access phase (psel & penable), no wait states.
// Assumes CLK_HZ >= 100 and NUM_SW <= 32. NUM_LEDS above MAX_LEDS stops
// elaboration.
module sysio_regs #(
    parameter int CLK_HZ       = 20000000,
    parameter int NUM_LEDS     = 2,
    parameter bit HAS_SWITCHES = 1'b0,
    parameter int NUM_SW       = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    psel,
    input  logic                                    penable,
    input  logic                                    pwrite,
    input  logic [9:0]                              paddr,
    input  logic [31:0]                             pwdata,
    output logic [31:0]                             prdata,
    output logic                                    bad_acc,
    output logic [((NUM_LEDS > 0) ? NUM_LEDS : 1)-1:0] led_o,
    input  logic [NUM_SW-1:0]                       sw_i
);
    import sysio_pkg::*;

    localparam int TICK_DIV = CLK_HZ / 100;

    if (NUM_LEDS > MAX_LEDS) begin : g_led_limit
        $error("NUM_LEDS exceeds MAX_LEDS");
    end

    logic  acc, wr;
    word_t led_rd, tick_cnt, ev_cnt, down_cnt, sw_zx, rd;
    word_t reld_q, misc_q;
    logic  [NUM_SW-1:0] sw_s;
    logic  hit;

    assign acc = psel & penable;
    assign wr  = acc & pwrite;

    // LED register, present only when NUM_LEDS > 0
    if (NUM_LEDS > 0) begin : g_led
        logic [NUM_LEDS-1:0] led_q;

        // Capture LED bits on a write to the LED word
        always_ff @(posedge clk) begin
            if (!rst_n)
                led_q <= '0;
            else if (wr && paddr == WA_LED)
                led_q <= pwdata[NUM_LEDS-1:0];
        end

        // Zero-extend for read-back
        always_comb begin
            led_rd = '0;
            led_rd[NUM_LEDS-1:0] = led_q;
        end

        assign led_o = led_q;

        AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && paddr == WA_LED) |=> $stable(led_o)); // R2
    end else begin : g_noled
        assign led_o  = '0;
        assign led_rd = '0;
    end

    // Reload value and scratch register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reld_q <= '0;
            misc_q <= '0;
        end else if (wr) begin
            if (paddr == WA_RELD) reld_q <= pwdata;
            if (paddr == WA_MISC) misc_q <= pwdata;
        end
    end

    sysio_tick #(.DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (tick_cnt)
    );

    sysio_presc u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (reld_q),
        .down_o   (down_cnt),
        .events_o (ev_cnt)
    );

    sysio_sync #(.W(NUM_SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sw_i),
        .q_o   (sw_s)
    );

    // Zero-extend synchronised switches
    always_comb begin
        sw_zx = '0;
        sw_zx[NUM_SW-1:0] = sw_s;
    end

    // Read decode; hit is low for words that hold no register
    always_comb begin
        rd  = '0;
        hit = 1'b1;
        case (paddr)
            WA_LED:   rd = led_rd;
            WA_TICK:  rd = tick_cnt;
            WA_EVCNT: rd = ev_cnt;
            WA_RELD:  rd = reld_q;
            WA_DOWN:  rd = down_cnt;
            WA_SW:    if (HAS_SWITCHES) rd = sw_zx; else hit = 1'b0;
            WA_MISC:  rd = misc_q;
            default:  hit = 1'b0;
        endcase
    end

    assign prdata  = rd;
    assign bad_acc = acc & ~hit;

    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |-> (prdata == '0)); // R9
    AST_MISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && paddr == WA_MISC) |=> $stable(misc_q)); // R8
    AST_RELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && paddr == WA_RELD) |=> $stable(reld_q)); // R5
endmodule

// File: tb/sim_sysio_regs.sv
module sim_sysio_regs;
    localparam int PERIOD = 10;
    localparam int CLKF   = 1000;
    localparam int DIV    = CLKF / 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [9:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  sw = '0;
    logic [31:0] prd0, prd1;
    logic        bad0, bad1;
    logic [2:0]  led0;
    logic [0:0]  led1;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    string cur_tag = "";

    always #(PERIOD/2) clk = ~clk;

    sysio_regs #(.CLK_HZ(CLKF), .NUM_LEDS(3), .HAS_SWITCHES(1'b1), .NUM_SW(4)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd0), .bad_acc(bad0),
        .led_o(led0), .sw_i(sw));

    sysio_regs #(.CLK_HZ(CLKF), .NUM_LEDS(0), .HAS_SWITCHES(1'b0), .NUM_SW(4)) u1 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd1), .bad_acc(bad1),
        .led_o(led1), .sw_i(sw));

    // Behavioural reference state
    int unsigned m_div, m_tick, m_down, m_ev, m_reld, m_misc;
    logic [2:0]  m_led;
    logic [3:0]  m_s1, m_s2;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_div <= 0; m_tick <= 0; m_down <= 0; m_ev <= 0;
            m_reld <= 0; m_misc <= 0; m_led <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            if (m_div == DIV - 1) begin m_div <= 0; m_tick <= m_tick + 1; end
            else m_div <= m_div + 1;
            if (m_down == 0) begin m_down <= m_reld; m_ev <= m_ev + 1; end
            else m_down <= m_down - 1;
            m_s1 <= sw;
            m_s2 <= m_s1;
            if (psel && penable && pwrite) begin
                if (paddr == 10'h000) m_led  <= pwdata[2:0];
                if (paddr == 10'h007) m_reld <= pwdata;
                if (paddr == 10'h013) m_misc <= pwdata;
            end
        end
    end

    function automatic bit mapped(input logic [9:0] a, input bit has_sw);
        case (a)
            10'h000, 10'h005, 10'h006, 10'h007, 10'h008, 10'h013: return 1'b1;
            10'h00A: return has_sw;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [9:0] a, input bit full);
        case (a)
            10'h000: return full ? {29'd0, m_led} : 32'd0;
            10'h005: return m_tick;
            10'h006: return m_ev;
            10'h007: return m_reld;
            10'h008: return m_down;
            10'h00A: return full ? {28'd0, m_s2} : 32'd0;
            10'h013: return m_misc;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [9:0] a);
        case (a)
            10'h000: return "R2";
            10'h005: return "R3";
            10'h006, 10'h008: return "R4";
            10'h007: return "R5";
            10'h00A: return "R7";
            10'h013: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            if (!rst_n) begin
                check32("R1", {29'd0, led0}, 32'd0);
            end else begin
                check32("R2", {29'd0, led0}, {29'd0, m_led});
                check32("R10", {31'd0, led1}, 32'd0);
                check32("R9", {31'd0, bad0}, {31'd0, psel & penable & ~mapped(paddr, 1'b1)});
                check32("R9", {31'd0, bad1}, {31'd0, psel & penable & ~mapped(paddr, 1'b0)});
                if (psel && penable && !pwrite) begin
                    check32(cur_tag != "" ? cur_tag : tag_of(paddr), prd0, exp_rd(paddr, 1'b1));
                    check32(cur_tag != "" ? cur_tag : tag_of(paddr), prd1, exp_rd(paddr, 1'b0));
                end
            end
        end
    end

    task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [9:0] a);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    // Read with a literal expectation on the full-featured instance
    task automatic rd_const(input logic [9:0] a, input logic [31:0] v, input string tag);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(negedge clk);
        check32(tag, prd0, v);
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values read back as zero
        rd_const(10'h007, 32'd0, "R1");
        rd_const(10'h013, 32'd0, "R1");
        rd_const(10'h008, 32'd0, "R1");
        rd_const(10'h000, 32'd0, "R1");

        // R2 / R10: LED width masking and the LED-less instance
        bus_wr(10'h000, 32'hFFFF_FFFF);
        rd_const(10'h000, 32'd7, "R2");
        bus_wr(10'h000, 32'h0000_0005);
        cur_tag = "R10"; bus_rd(10'h000); cur_tag = "";
        bus_wr(10'h000, 32'hFFFF_FFFA);
        bus_rd(10'h000);

        // R8: scratch register
        bus_wr(10'h013, 32'hDEAD_BEEF);
        rd_const(10'h013, 32'hDEAD_BEEF, "R8");
        bus_wr(10'h013, 32'h1234_5678);
        bus_rd(10'h013);

        // R3 / R6: writes to read-only counters
        bus_wr(10'h005, 32'hAAAA_5555);
        bus_rd(10'h005);
        bus_wr(10'h006, 32'h0000_0100);
        bus_wr(10'h008, 32'h0000_0042);
        cur_tag = "R6"; bus_rd(10'h006); bus_rd(10'h008); cur_tag = "";

        // R4: reload period of 6 clocks, sampled densely
        bus_wr(10'h007, 32'd5);
        for (int i = 0; i < 12; i++) begin
            bus_rd(10'h008);
            bus_rd(10'h006);
        end

        // R5: new reload value waits for the next underflow
        bus_wr(10'h007, 32'd40);
        cur_tag = "R5";
        for (int i = 0; i < 30; i++) bus_rd(10'h008);
        cur_tag = "";
        bus_wr(10'h007, 32'd2);
        for (int i = 0; i < 20; i++) bus_rd(10'h008);

        // R7: switch synchroniser depth, read right after each change
        @(posedge clk); #1 sw = 4'b1010;
        bus_rd(10'h00A);
        bus_rd(10'h00A);
        @(posedge clk); #1 sw = 4'b0101;
        for (int i = 0; i < 4; i++) bus_rd(10'h00A);
        @(posedge clk); #1 sw = 4'b1111;
        repeat (3) @(posedge clk);
        rd_const(10'h00A, 32'h0000_000F, "R7");

        // R9: unmapped words read zero, writes there change nothing
        bus_rd(10'h001);
        bus_rd(10'h009);
        bus_rd(10'h00B);
        bus_rd(10'h014);
        bus_rd(10'h3FF);
        bus_wr(10'h001, 32'hFFFF_FFFF);
        bus_wr(10'h3FF, 32'hFFFF_FFFF);
        cur_tag = "R9";
        bus_rd(10'h000); bus_rd(10'h007); bus_rd(10'h013);
        cur_tag = "";

        // R3: watch several timebase ticks
        for (int i = 0; i < 40; i++) bus_rd(10'h005);

        finish_run();
    end
endmodule